// File: doc/BRIEF.md
# Pipelined Bus Cycle Controller

This block is the bus-facing sequencer of a 32-bit processor core. It takes transfer requests from the core through a valid/ready port. Each request carries a word address, byte enables, a write flag, a data/code flag, a memory/I-O flag and write data. For each request it runs one external bus cycle. A cycle opens with a one-state active-low address strobe. It then waits in its data phase until the external system pulls the active-low ready input low.

A cycle needs at least two bus states: an address state followed by a data state. The data state repeats for as long as ready stays high, with no upper limit. The external system can also pull the active-low next-address input low while a cycle waits for ready. If another request is pending at that point, the controller puts the following cycle's address and definition on the bus early and strobes it in a state that overlaps the current data phase. The following cycle then starts directly in a pipelined data state.

Each completed cycle returns a one-state response pulse. A read response carries the data captured on the bus input in the state where ready was sampled low. Responses come back in request order. The data bus is split into an input, an output and an output enable.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While rst_ni is low and in the first state after it rises, bus_ads_n_o is 1, bus_data_oe_o is 0, rsp_valid_o is 0 and req_ready_o is 1.
- R2: From idle, an accepted request strobes bus_ads_n_o low for one state (the address state). The data state follows in the next state. If bus_ready_ni is low in that first data state, rsp_valid_o pulses in the state after, so that back-to-back cycles complete every 2 states.
- R3: While bus_ready_ni stays high in a data state, the data state repeats without limit. With a ready delay of d sampled data states, non-pipelined back-to-back cycles complete every d+2 states.
- R4: In a non-pipelined cycle, bus_addr_o, bus_be_o, bus_wr_o, bus_dc_o and bus_mio_o do not change from the address state to the state in which ready is sampled.
- R5: If bus_na_ni is 0 in a waiting data state (before ready) and a request is pending, the next state strobes the pending request's address while the current cycle's data phase is still open.
- R6: bus_ads_n_o is low for exactly one state per cycle and never low without an accepted request. Two strobe states are never adjacent.
- R7: bus_na_ni is ignored when no request is pending. The cycle completes without an extra strobe and the bus returns to idle.
- R8: bus_data_oe_o is 1 exactly in the data-phase states of a write cycle, up to and including the state where ready is sampled. In those states bus_data_o equals that write's data. Otherwise bus_data_oe_o is 0.
- R9: For a read, rsp_rdata_o equals bus_data_i as sampled in the state where ready was low. Responses come back in request order. A write with bus_be_o bit b at 1 updates byte b (bits 8b+7..8b) only.
- R10: Pipelined back-to-back cycles keep the same completion rate as non-pipelined ones: d+2 states per cycle for a ready delay of d.
- R11: bus_ready_ni is ignored in idle, in the address state and in the first data state of a pipelined cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus state clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this state when valid |
| req_addr_i | input | AW | Word address |
| req_be_i | input | BW | Byte enables, active high |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_dc_i | input | 1 | 1 = data, 0 = code |
| req_mio_i | input | 1 | 1 = memory, 0 = I-O |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | Cycle completion pulse |
| rsp_rdata_o | output | DW | Read data of the completed read |
| bus_addr_o | output | AW | Bus word address |
| bus_be_o | output | BW | Bus byte enables |
| bus_wr_o | output | 1 | Bus write/read definition |
| bus_dc_o | output | 1 | Bus data/code definition |
| bus_mio_o | output | 1 | Bus memory/I-O definition |
| bus_ads_n_o | output | 1 | Address strobe, active low |
| bus_ready_ni | input | 1 | Cycle acknowledge, active low |
| bus_na_ni | input | 1 | Next-address request, active low |
| bus_data_i | input | DW | Read data from the bus |
| bus_data_o | output | DW | Write data to the bus |
| bus_data_oe_o | output | 1 | Write data output enable |

## Verification
The assertions check the state-to-state rules on every cycle:
- the address state is always followed by a data state;
- two strobe states are never adjacent;
- a waiting data state repeats;
- the first pipelined data state ignores ready;
- the address and definition hold during a non-pipelined cycle;
- a sampled ready always yields a response.

Other properties need a bus partner and only the bench scenarios can show them:
- end-to-end data correctness through a byte-enabled memory;
- response order;
- completion spacing under different ready delays;
- that pipelining actually overlaps a strobe with an open cycle;
- that spurious ready pulses in the ignored states leave timing and data unchanged.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,  // no cycle
    ST_ADR,   // address state, strobe low
    ST_DAT,   // data state, ready sampled
    ST_PDAT,  // first data state of a pipelined cycle, ready ignored
    ST_OVL,   // data state with next address strobed
    ST_OWT    // data state waiting, next address already out
  } bus_st_e;
endpackage

// File: rtl/bcc_fsm.sv
module bcc_fsm
  import bcc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_valid_i,
  input  logic    rdy_i,
  input  logic    na_i,
  input  logic    d_wr_i,
  output bus_st_e st_o,
  output logic    req_ready_o,
  output logic    load_a_o,
  output logic    load_d_o,
  output logic    done_o,
  output logic    ads_o,
  output logic    drive_o
);
  bus_st_e st_q, st_d;
  logic    data_st;

  assign data_st = (st_q == ST_DAT) || (st_q == ST_OVL) || (st_q == ST_OWT);
  assign done_o  = data_st && rdy_i;
  assign ads_o   = (st_q == ST_ADR) || (st_q == ST_OVL);
  assign drive_o = d_wr_i && (data_st || st_q == ST_PDAT);

  always_comb begin
    req_ready_o = 1'b0;
    unique case (st_q)
      ST_IDLE: req_ready_o = 1'b1;
      ST_DAT:  req_ready_o = rdy_i || na_i;
      ST_PDAT: req_ready_o = na_i;
      default: req_ready_o = 1'b0;
    endcase
  end

  assign load_a_o = req_ready_o && req_valid_i;
  assign load_d_o = (st_q == ST_ADR) || (((st_q == ST_OVL) || (st_q == ST_OWT)) && rdy_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) st_d = ST_ADR;
      ST_ADR:  st_d = ST_DAT;
      ST_DAT: begin
        if (rdy_i)                   st_d = req_valid_i ? ST_ADR : ST_IDLE;
        else if (na_i && req_valid_i) st_d = ST_OVL;
      end
      ST_PDAT: st_d = (na_i && req_valid_i) ? ST_OVL : ST_DAT;
      ST_OVL:  st_d = rdy_i ? ST_PDAT : ST_OWT;
      ST_OWT:  if (rdy_i) st_d = ST_PDAT;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;

  // R2
  adr_then_dat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ADR) |=> (st_q == ST_DAT));
  // R6
  ads_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ads_o |=> !ads_o);
  // R3
  wait_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DAT && !rdy_i && !(na_i && req_valid_i)) |=> (st_q == ST_DAT));
  // R11
  pdat_ign_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PDAT && !(na_i && req_valid_i)) |=> (st_q == ST_DAT));
endmodule

// File: rtl/bcc_regs.sv
module bcc_regs #(
  parameter int AW = 30,
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_a_i,
  input  logic          load_d_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [BW-1:0] req_be_i,
  input  logic          req_wr_i,
  input  logic          req_dc_i,
  input  logic          req_mio_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic [AW-1:0] a_addr_o,
  output logic [BW-1:0] a_be_o,
  output logic          a_wr_o,
  output logic          a_dc_o,
  output logic          a_mio_o,
  output logic          d_wr_o,
  output logic [DW-1:0] d_wdata_o
);
  logic [DW-1:0] a_wdata_q;

  // address-side copy: last strobed cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_addr_o  <= '0;
      a_be_o    <= '0;
      a_wr_o    <= 1'b0;
      a_dc_o    <= 1'b0;
      a_mio_o   <= 1'b0;
      a_wdata_q <= '0;
    end else if (load_a_i) begin
      a_addr_o  <= req_addr_i;
      a_be_o    <= req_be_i;
      a_wr_o    <= req_wr_i;
      a_dc_o    <= req_dc_i;
      a_mio_o   <= req_mio_i;
      a_wdata_q <= req_wdata_i;
    end
  end

  // data-side copy: cycle currently in its data phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_wr_o    <= 1'b0;
      d_wdata_o <= '0;
    end else if (load_d_i) begin
      d_wr_o    <= a_wr_o;
      d_wdata_o <= a_wdata_q;
    end
  end
endmodule

// File: rtl/bcc_rsp.sv
module bcc_rsp #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic          d_wr_i,
  input  logic [DW-1:0] bus_data_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= done_i;
      if (done_i && !d_wr_i) rsp_rdata_o <= bus_data_i;
    end
  end
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int AW = 30,
  parameter int DW = 32,
  localparam int BW = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [BW-1:0] req_be_i,
  input  logic          req_wr_i,
  input  logic          req_dc_i,
  input  logic          req_mio_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [BW-1:0] bus_be_o,
  output logic          bus_wr_o,
  output logic          bus_dc_o,
  output logic          bus_mio_o,
  output logic          bus_ads_n_o,
  input  logic          bus_ready_ni,
  input  logic          bus_na_ni,
  input  logic [DW-1:0] bus_data_i,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_data_oe_o
);
  bus_st_e st;
  logic    load_a, load_d, done, ads, drive, d_wr;

  bcc_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .rdy_i       (!bus_ready_ni),
    .na_i        (!bus_na_ni),
    .d_wr_i      (d_wr),
    .st_o        (st),
    .req_ready_o (req_ready_o),
    .load_a_o    (load_a),
    .load_d_o    (load_d),
    .done_o      (done),
    .ads_o       (ads),
    .drive_o     (drive)
  );

  bcc_regs #(.AW(AW), .DW(DW), .BW(BW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_a_i    (load_a),
    .load_d_i    (load_d),
    .req_addr_i  (req_addr_i),
    .req_be_i    (req_be_i),
    .req_wr_i    (req_wr_i),
    .req_dc_i    (req_dc_i),
    .req_mio_i   (req_mio_i),
    .req_wdata_i (req_wdata_i),
    .a_addr_o    (bus_addr_o),
    .a_be_o      (bus_be_o),
    .a_wr_o      (bus_wr_o),
    .a_dc_o      (bus_dc_o),
    .a_mio_o     (bus_mio_o),
    .d_wr_o      (d_wr),
    .d_wdata_o   (bus_data_o)
  );

  bcc_rsp #(.DW(DW)) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done),
    .d_wr_i      (d_wr),
    .bus_data_i  (bus_data_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  assign bus_ads_n_o   = !ads;
  assign bus_data_oe_o = drive;

  // R4
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ADR || (st == ST_DAT && bus_ready_ni && !(!bus_na_ni && req_valid_i)))
    |=> ($stable(bus_addr_o) && $stable(bus_be_o) && $stable({bus_wr_o, bus_dc_o, bus_mio_o})));
  // R9
  done_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> rsp_valid_o);
  // R5
  pipe_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st == ST_DAT || st == ST_PDAT) && !bus_na_ni && req_valid_i && !(st == ST_DAT && !bus_ready_ni))
    |=> (!bus_ads_n_o && st == ST_OVL));
  // R8
  oe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_DAT && !bus_ready_ni && !req_valid_i) |=> !bus_data_oe_o);
endmodule

// File: tb/sim_bus_cycle_ctrl.sv
module sim_bus_cycle_ctrl;
  localparam int AW = 30;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_ni = 1'b0;
  logic          req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [BW-1:0] req_be = '0;
  logic          req_wr = 1'b0, req_dc = 1'b1, req_mio = 1'b1;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] bus_addr;
  logic [BW-1:0] bus_be;
  logic          bus_wr, bus_dc, bus_mio, bus_ads_n;
  logic          bus_ready_n = 1'b1;
  logic          na_on = 1'b0;
  logic [DW-1:0] bus_din = '0;
  logic [DW-1:0] bus_dout;
  logic          bus_oe;

  bus_cycle_ctrl #(.AW(AW), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_be_i(req_be), .req_wr_i(req_wr),
    .req_dc_i(req_dc), .req_mio_i(req_mio), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .bus_addr_o(bus_addr), .bus_be_o(bus_be), .bus_wr_o(bus_wr),
    .bus_dc_o(bus_dc), .bus_mio_o(bus_mio), .bus_ads_n_o(bus_ads_n),
    .bus_ready_ni(bus_ready_n), .bus_na_ni(!na_on),
    .bus_data_i(bus_din), .bus_data_o(bus_dout), .bus_data_oe_o(bus_oe)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic [BW-1:0] be;
    logic          wr;
    logic [DW-1:0] wd;
    logic [DW-1:0] rd;
  } item_t;

  item_t exp_bus[$];
  item_t exp_rsp[$];
  item_t mq[$];
  logic [DW-1:0] mem [16];
  logic [DW-1:0] ref_mem [16];
  int  tests = 0, fails = 0;
  int  delay = 0, age = 0, cyc = 0, last_rsp = -1, pipe_issues = 0;
  int  gaps[$];
  bit  spurious = 1'b0, mon_en = 1'b0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [BW-1:0] be);
    logic [DW-1:0] r = old;
    for (int b = 0; b < BW; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  // driver: call at a negedge; returns at the negedge after acceptance
  task automatic issue(logic [AW-1:0] a, logic [BW-1:0] be, logic wr, logic [DW-1:0] wd);
    item_t it;
    bit acc;
    it.addr = a; it.be = be; it.wr = wr; it.wd = wd; it.rd = ref_mem[a[3:0]];
    if (wr) ref_mem[a[3:0]] = merge(ref_mem[a[3:0]], wd, be);
    exp_bus.push_back(it);
    exp_rsp.push_back(it);
    req_addr = a; req_be = be; req_wr = wr; req_wdata = wd; req_valid = 1'b1;
    do begin
      #3 acc = req_ready;
      @(negedge clk);
    end while (!acc);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while (exp_rsp.size() > 0 && t < 300) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chk(exp_rsp.size() == 0, "R9 all responses returned", exp_rsp.size(), 0);
  endtask

  task automatic chk_gaps(int want, string tag);
    chk(gaps.size() > 0, {tag, " gap count"}, gaps.size(), 1);
    foreach (gaps[i]) chk(gaps[i] == want, tag, gaps[i], want);
  endtask

  task automatic start_burst(int d, bit na, bit sp);
    delay = d; na_on = na; spurious = sp;
    gaps.delete(); last_rsp = -1;
    @(negedge clk);
  endtask

  // bus partner and monitor
  always begin
    item_t e;
    bit completed, pushed, exp_oe, piped;
    @(negedge clk);
    bus_ready_n = 1'b1;
    if (mq.size() > 0 && age == delay) bus_ready_n = 1'b0;
    if (spurious && (mq.size() == 0 || age < 0)) bus_ready_n = 1'b0;
    bus_din = (mq.size() > 0 && !mq[0].wr) ? mem[mq[0].addr[3:0]] : '0;
    #3;
    if (mon_en) begin
      cyc++;
      exp_oe = (mq.size() > 0) && mq[0].wr;
      chk(bus_oe == exp_oe, "R8 output enable", bus_oe, exp_oe);
      if (exp_oe) chk(bus_dout == mq[0].wd, "R8 write data", bus_dout, mq[0].wd);
      completed = (bus_ready_n == 1'b0) && (mq.size() > 0) && (age >= 0);
      if (completed) begin
        e = mq.pop_front();
        if (e.wr) mem[e.addr[3:0]] = merge(mem[e.addr[3:0]], bus_dout, e.be);
      end
      pushed = 1'b0;
      if (!bus_ads_n) begin
        if (exp_bus.size() == 0) chk(1'b0, "R6 strobe without request", 1, 0);
        else begin
          e = exp_bus.pop_front();
          chk(bus_addr == e.addr && bus_be == e.be && bus_wr == e.wr,
              "R4 cycle address/definition", {bus_addr, bus_be, bus_wr}, {e.addr, e.be, e.wr});
          piped = (mq.size() > 0) || completed;
          if (piped) pipe_issues++;
          mq.push_back(e);
          pushed = 1'b1;
        end
      end
      if (completed) age = (mq.size() > 0) ? -1 : 0;
      else if (pushed && mq.size() == 1) age = 0;
      else if (mq.size() > 0) age++;
      if (rsp_valid) begin
        if (exp_rsp.size() == 0) chk(1'b0, "R9 unexpected response", 1, 0);
        else begin
          e = exp_rsp.pop_front();
          if (!e.wr) chk(rsp_rdata == e.rd, "R9 read data", rsp_rdata, e.rd);
          if (last_rsp >= 0) gaps.push_back(cyc - last_rsp);
          last_rsp = cyc;
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int p0;
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'h1000_0000 + i;
      ref_mem[i] = 32'h1000_0000 + i;
    end
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(bus_ads_n == 1'b1 && bus_oe == 1'b0 && rsp_valid == 1'b0, "R1 reset outputs",
        {bus_ads_n, bus_oe, rsp_valid}, 3'b100);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    #3;
    chk(bus_ads_n == 1'b1 && bus_oe == 1'b0 && rsp_valid == 1'b0 && req_ready == 1'b1,
        "R1 after reset", {bus_ads_n, bus_oe, rsp_valid, req_ready}, 4'b1001);

    // R2/R8: zero-wait non-pipelined writes then reads
    start_burst(0, 0, 0);
    for (int i = 0; i < 4; i++) issue(AW'(i), 4'hF, 1'b1, 32'hA5A5_0000 + i);
    drain();
    chk_gaps(2, "R2 write spacing");
    start_burst(0, 0, 0);
    for (int i = 0; i < 4; i++) issue(AW'(i), 4'hF, 1'b0, '0);
    drain();
    chk_gaps(2, "R2 read spacing");

    // R3: three wait states
    start_burst(3, 0, 0);
    for (int i = 0; i < 3; i++) issue(AW'(i + 4), 4'hF, 1'b0, '0);
    drain();
    chk_gaps(5, "R3 wait-state spacing");

    // R5/R10: pipelined with one wait state, compare with non-pipelined
    start_burst(1, 0, 0);
    p0 = pipe_issues;
    for (int i = 0; i < 4; i++) issue(AW'(i), 4'hF, 1'b0, '0);
    drain();
    chk_gaps(3, "R10 non-pipelined spacing d=1");
    chk(pipe_issues == p0, "R5 no overlap without next-address", pipe_issues - p0, 0);
    start_burst(1, 1, 0);
    p0 = pipe_issues;
    for (int i = 0; i < 4; i++) issue(AW'(i + 8), 4'hF, 1'b1, 32'h5A00_0000 + i);
    for (int i = 0; i < 4; i++) issue(AW'(i + 8), 4'hF, 1'b0, '0);
    drain();
    chk(pipe_issues - p0 >= 6, "R5 overlapped strobes", pipe_issues - p0, 6);
    chk_gaps(3, "R10 pipelined spacing d=1");

    // R7: next-address with nothing pending
    start_burst(2, 1, 0);
    p0 = pipe_issues;
    issue(AW'(5), 4'hF, 1'b0, '0);
    drain();
    repeat (6) @(negedge clk);
    chk(pipe_issues == p0, "R7 no overlap when nothing pending", pipe_issues - p0, 0);
    #3 chk(bus_ads_n == 1'b1 && bus_oe == 1'b0, "R7 idle after cycle", {bus_ads_n, bus_oe}, 2'b10);

    // R9: partial byte enables then read back
    start_burst(1, 0, 0);
    issue(AW'(12), 4'b0101, 1'b1, 32'hDEAD_BEEF);
    issue(AW'(13), 4'b1000, 1'b1, 32'hCAFE_F00D);
    issue(AW'(12), 4'hF, 1'b0, '0);
    issue(AW'(13), 4'hF, 1'b0, '0);
    drain();

    // R11: ready pulses in ignored states
    start_burst(2, 0, 1);
    for (int i = 0; i < 3; i++) issue(AW'(i), 4'hF, 1'b0, '0);
    drain();
    chk_gaps(4, "R11 spurious ready non-pipelined");
    start_burst(1, 1, 1);
    for (int i = 0; i < 4; i++) issue(AW'(i + 8), 4'hF, 1'b0, '0);
    drain();
    chk_gaps(3, "R11 spurious ready pipelined");
    spurious = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule